// File: doc/BRIEF.md
# Boot Memory Alias Controller

This block chooses which memory answers at address zero after reset: the on-chip ROM or the Flash array. It holds a single alias flag. When reset is released, the block reads the first two Flash words through its own Flash port. It sets the flag only if a ROM is fitted and both words are blank (all ones). While the check runs, the block raises a busy output and holds off CPU accesses.

When the check is done, CPU accesses that fall inside a low alias window go to ROM while the flag is set, and to Flash while it is clear. Addresses outside the window always decode to their normal targets. Software sees the flag in bit 0 of a 32-bit control register, which sits at offset 0x0F0 of the register space. Software can only clear the flag, by writing a one to that bit. Once the flag is clear, only a new reset can evaluate it again.

Top module: `boot_alias_ctl`

## Requirements
- R1: When reset is released, the flag ends up set only if `rom_present` is high and Flash words 0 (byte 0x0) and 1 (byte 0x4) both read 0xFFFFFFFF. In every other case it ends up clear.
- R2: With a ROM fitted, `boot_busy` is high from reset release through the first two clock edges and goes low after the third edge. While busy, `rom_en` stays low and `flash_en` serves only the check reads.
- R3: When not busy and the flag is set, a CPU access below `WIN_BYTES` asserts `rom_en` with `rom_addr` equal to the CPU address, and `flash_en` stays low.
- R4: When not busy and the flag is clear, a CPU access below `WIN_BYTES` asserts `flash_en` with `flash_addr` equal to the CPU address, and `rom_en` stays low.
- R5: Outside the window, the routing ignores the flag. Addresses from `ROM_BASE` up to `ROM_BASE+ROM_BYTES` go to ROM, with `rom_addr` set to the address minus `ROM_BASE`. Addresses below `FLASH_BYTES` go to Flash.
- R6: A register write to offset 0x0F0 with data bit 0 equal to 1 clears the flag. The very next CPU access to address 0 goes to Flash. A write with bit 0 equal to 0 leaves the flag unchanged.
- R7: A register read at offset 0x0F0 returns the flag in bit 0 and zeros in bits 31:1, valid one cycle after the request. Writes to bits 31:1 have no effect, and reads at any other offset return zero.
- R8: Software cannot set the flag again once it is clear. A new reset evaluates it again.
- R9: When `rom_present` is low, the block issues no Flash check reads, busy lasts one cycle, and the flag stays clear.
- R10: A register write that arrives while `boot_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_present | input | 1 | Strap: high when a ROM is fitted |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the request |
| cpu_req | input | 1 | CPU memory access request |
| cpu_addr | input | 32 | CPU byte address |
| boot_busy | output | 1 | Boot check running; CPU must stall |
| rom_en | output | 1 | ROM access enable |
| rom_addr | output | 32 | ROM byte offset |
| flash_en | output | 1 | Flash access enable (check read or CPU) |
| flash_addr | output | 32 | Flash byte address |
| flash_rdata | input | 32 | Flash read data, one cycle after `flash_en` |

## Verification
A wrong flag is visible at the ports at once. It shows up as the wrong enable on the first CPU access to the window, and one cycle later as the wrong bit 0 in a control register read. A check state machine that ends early or late shows in `boot_busy` at the second or third edge after reset release. It can also show as a flag built from a data word that was captured in the wrong cycle. A clear that lands late, or a set that software can cause, shows on the access right after the write.

// File: rtl/boot_alias_ctl.sv
module boot_alias_ctl #(
  parameter logic [31:0] ROM_BASE    = 32'h0100_0000,
  parameter logic [31:0] ROM_BYTES   = 32'h0000_2000,
  parameter logic [31:0] FLASH_BYTES = 32'h0004_0000,
  parameter logic [31:0] WIN_BYTES   = ROM_BYTES,
  parameter logic [11:0] CTL_OFS     = 12'h0F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rom_present,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cpu_req,
  input  logic [31:0] cpu_addr,
  output logic        boot_busy,
  output logic        rom_en,
  output logic [31:0] rom_addr,
  output logic        flash_en,
  output logic [31:0] flash_addr,
  input  logic [31:0] flash_rdata
);
  localparam logic [31:0] ONES = '1;
  localparam logic [31:0] ROM_END = ROM_BASE + ROM_BYTES;

  typedef enum logic [1:0] {ST_RD0, ST_RD1, ST_EVAL, ST_DONE} chk_t;

  chk_t st;
  logic alias_q;
  logic word0_ok;

  assign boot_busy = (st != ST_DONE);

  wire reg_hit = reg_en && (reg_addr == CTL_OFS);
  wire wr_clr  = reg_hit && reg_we && reg_wdata[0] && !boot_busy;
  wire chk_rd  = (st == ST_RD0 && rom_present) || (st == ST_RD1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RD0;
      alias_q  <= 1'b0;
      word0_ok <= 1'b0;
    end else begin
      case (st)
        ST_RD0:  st <= rom_present ? ST_RD1 : ST_DONE;
        ST_RD1: begin
          word0_ok <= (flash_rdata == ONES);
          st       <= ST_EVAL;
        end
        ST_EVAL: begin
          alias_q <= word0_ok && (flash_rdata == ONES);
          st      <= ST_DONE;
        end
        default: if (wr_clr) alias_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= (reg_hit && !reg_we) ? {31'b0, alias_q} : 32'b0;
  end

  wire in_win    = cpu_addr < WIN_BYTES;
  wire rom_rng   = (cpu_addr >= ROM_BASE) && (cpu_addr < ROM_END);
  wire flash_rng = cpu_addr < FLASH_BYTES;
  wire to_rom    = in_win ? alias_q  : rom_rng;
  wire to_flash  = in_win ? !alias_q : flash_rng;

  assign rom_en     = !boot_busy && cpu_req && to_rom;
  assign rom_addr   = in_win ? cpu_addr : cpu_addr - ROM_BASE;
  assign flash_en   = boot_busy ? chk_rd : (cpu_req && to_flash);
  assign flash_addr = boot_busy ? {29'b0, (st == ST_RD1), 2'b00} : cpu_addr;
endmodule

// File: rtl/boot_alias_ctl_sva.sv
module boot_alias_ctl_sva #(
  parameter logic [31:0] WIN_BYTES = 32'h2000,
  parameter logic [11:0] CTL_OFS   = 12'h0F0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rom_present,
  input logic        boot_busy,
  input logic        alias_q,
  input logic        reg_en,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic        wbit0,
  input logic [31:0] reg_rdata,
  input logic        cpu_req,
  input logic [31:0] cpu_addr,
  input logic        rom_en,
  input logic        flash_en
);
  a_r2_no_rom_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |-> !rom_en);

  a_r3_window_to_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_busy && cpu_req && cpu_addr < WIN_BYTES && alias_q) |-> (rom_en && !flash_en));

  a_r4_window_to_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_busy && cpu_req && cpu_addr < WIN_BYTES && !alias_q) |-> (flash_en && !rom_en));

  a_r6_clear_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_busy && reg_en && reg_we && reg_addr == CTL_OFS && wbit0) |=> !alias_q);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:1] == 31'b0);

  a_r8_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_busy && $past(!boot_busy) && $past(!alias_q)) |-> !alias_q);

  a_r9_no_check_without_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_busy && !rom_present) |-> !flash_en);
endmodule

bind boot_alias_ctl boot_alias_ctl_sva #(.WIN_BYTES(WIN_BYTES), .CTL_OFS(CTL_OFS)) u_sva (
  .clk(clk), .rst_n(rst_n), .rom_present(rom_present), .boot_busy(boot_busy),
  .alias_q(alias_q), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .wbit0(reg_wdata[0]), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
  .cpu_addr(cpu_addr), .rom_en(rom_en), .flash_en(flash_en)
);

// File: tb/sim_boot_alias_ctl.sv
module sim_boot_alias_ctl;
  localparam logic [31:0] ROM_BASE = 32'h0100_0000;
  localparam logic [11:0] OFS = 12'h0F0;

  logic clk = 0, rst_n = 0, rom_present = 0;
  logic reg_en = 0, reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cpu_req = 0;
  logic [31:0] cpu_addr = '0;
  logic boot_busy, rom_en, flash_en;
  logic [31:0] rom_addr, flash_addr, flash_rdata;
  logic [31:0] fmem [4];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (flash_en) flash_rdata <= fmem[flash_addr[3:2]];

  boot_alias_ctl u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit rp, input logic [31:0] w0, input logic [31:0] w1);
    @(negedge clk);
    rst_n = 0; rom_present = rp;
    fmem[0] = w0; fmem[1] = w1; fmem[2] = 32'hA5A5_0002; fmem[3] = 32'hA5A5_0003;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_check();
    repeat (3) @(negedge clk);
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic cpu_probe(input logic [31:0] a, input bit exp_rom, input logic [31:0] exp_off, input string req);
    cpu_req = 1; cpu_addr = a;
    #1;
    check(rom_en == exp_rom && flash_en == !exp_rom, req, {30'b0, rom_en, flash_en}, {30'b0, exp_rom, !exp_rom});
    if (exp_rom) check(rom_addr == exp_off, req, rom_addr, exp_off);
    else         check(flash_addr == exp_off, req, flash_addr, exp_off);
    cpu_req = 0;
  endtask

  task automatic t_blank_boot();
    logic [31:0] d;
    do_reset(1, '1, '1);
    check(boot_busy == 1, "R2 busy at release", {31'b0, boot_busy}, 1);
    check(flash_en == 1 && flash_addr == 0, "R2 check read word0", flash_addr, 0);
    @(negedge clk);
    check(flash_en == 1 && flash_addr == 4, "R2 check read word1", flash_addr, 4);
    @(negedge clk);
    check(boot_busy == 1 && rom_en == 0, "R2 busy after two edges", {31'b0, boot_busy}, 1);
    @(negedge clk);
    check(boot_busy == 0, "R2 idle after three edges", {31'b0, boot_busy}, 0);
    reg_read(OFS, d);
    check(d == 1, "R1 R7 flag set on blank flash", d, 1);
    @(negedge clk);
    cpu_probe(32'h0000_0010, 1, 32'h10, "R3 window to ROM");
  endtask

  task automatic t_register();
    logic [31:0] d;
    reg_read(12'h0F4, d);
    check(d == 0, "R7 other offset reads zero", d, 0);
    reg_write(OFS, 32'hFFFF_FFFE);
    reg_read(OFS, d);
    check(d == 1, "R6 R7 bit0=0 and reserved writes ignored", d, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    reg_write(OFS, 32'h1);
    cpu_probe(32'h0, 0, 32'h0, "R6 next access goes to Flash");
    cpu_probe(32'h0000_0100, 0, 32'h100, "R4 window to Flash");
    reg_write(OFS, 32'h1);
    reg_write(OFS, 32'hFFFF_FFFF);
    reg_read(OFS, d);
    check(d == 0, "R8 software cannot set flag", d, 0);
    do_reset(1, '1, '1);
    wait_check();
    reg_read(OFS, d);
    check(d == 1, "R8 reset re-evaluates flag", d, 1);
  endtask

  task automatic t_outside();
    @(negedge clk);
    cpu_probe(ROM_BASE + 32'h40, 1, 32'h40, "R5 ROM region with flag set");
    cpu_probe(32'h0000_3000, 0, 32'h3000, "R5 Flash beyond window with flag set");
    reg_write(OFS, 32'h1);
    cpu_probe(ROM_BASE + 32'h40, 1, 32'h40, "R5 ROM region with flag clear");
    cpu_probe(32'h0000_3000, 0, 32'h3000, "R5 Flash beyond window with flag clear");
  endtask

  task automatic t_not_blank();
    logic [31:0] d;
    do_reset(1, '1, 32'h1234_5678);
    wait_check();
    reg_read(OFS, d);
    check(d == 0, "R1 word1 not blank", d, 0);
    do_reset(1, 32'hFFFF_FFFE, '1);
    wait_check();
    reg_read(OFS, d);
    check(d == 0, "R1 word0 not blank", d, 0);
  endtask

  task automatic t_no_rom();
    logic [31:0] d;
    do_reset(0, '1, '1);
    check(boot_busy == 1 && flash_en == 0, "R9 no check read without ROM", {31'b0, flash_en}, 0);
    @(negedge clk);
    check(boot_busy == 0, "R9 busy one cycle", {31'b0, boot_busy}, 0);
    reg_read(OFS, d);
    check(d == 0, "R9 flag clear without ROM", d, 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    do_reset(1, '1, '1);
    reg_en = 1; reg_we = 1; reg_addr = OFS; reg_wdata = 32'h1;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    repeat (2) @(negedge clk);
    reg_read(OFS, d);
    check(d == 1, "R10 write during busy ignored", d, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_blank_boot();
    t_register();
    t_clear();
    t_outside();
    t_not_blank();
    t_no_rom();
    t_busy_write();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule